// File: doc/BRIEF.md
# Surface Normal Pre-Normalizer

This block shrinks a per-pixel surface normal from three wide two's-complement components to three narrow sign-magnitude components. It keeps the direction of the vector: every component is divided by the same power of two, and the component with the largest magnitude sets that power. The block sits at the output of a per-primitive rasterizer, where it narrows the normal before it leaves the chip.

Each input component is split into a sign and a magnitude. The magnitude is formed cheaply by inverting the low bits whenever the sign is set. This is the ones-complement value, so a negative input reads one unit low. The three magnitudes are combined by OR. The position of the leading one of that OR gives the shift count K: the smallest right shift that brings the largest magnitude into the output magnitude width. The bits of K switch a chain of fixed shift stages of 1, 2, 4 and 8 places. Each stage is either applied or bypassed. One triple is accepted per clock, and the result appears a fixed three cycles later.

Top module: `normal_prescaler`

## Requirements
- R1: `out_vld` is `in_vld` delayed by exactly three clock cycles. A new triple is accepted on every cycle, and back-to-back and gapped inputs are both handled without loss.
- R2: The sign of a component is its input bit 23. Its magnitude is input bits 22:0, inverted when bit 23 is 1, with no +1 correction. For example, -5 gives magnitude 4.
- R3: All three magnitudes are shifted right, with truncation, by one shared K. K is the smallest value for which the largest of the three magnitudes is below 2048.
- R4: When all three magnitudes are below 2048, K is 0 and each output magnitude equals its input magnitude.
- R5: Each 12-bit output holds the sign in bit 11 and the magnitude in bits 10:0. Output x, y and z correspond to input x, y and z.
- R6: An output whose shifted magnitude is zero carries sign 0. This covers the input -1 and small components that shift to zero.
- R7: When K is greater than 0, at least one output magnitude has bit 10 set.
- R8: While reset is asserted, `out_vld` is 0 and all three outputs are 0.
- R9: A full-scale magnitude (bits 22:0 all ones after inversion) gives K = 12 and output magnitude 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input triple valid |
| in_x | input | 24 | Normal x component, two's complement |
| in_y | input | 24 | Normal y component, two's complement |
| in_z | input | 24 | Normal z component, two's complement |
| out_vld | output | 1 | Output triple valid |
| out_x | output | 12 | x result: bit 11 sign, bits 10:0 magnitude |
| out_y | output | 12 | y result: bit 11 sign, bits 10:0 magnitude |
| out_z | output | 12 | z result: bit 11 sign, bits 10:0 magnitude |

## Verification
The assertions assume the data inputs may hold any value in any cycle. They assume only that `in_vld` is a known 0 or 1 from the moment reset is released, because the valid pipeline is compared to itself one stage later. The bench holds `in_vld` low all through reset and drives it on every falling edge afterwards. It covers every component value class the shift logic distinguishes: zero, minus one, values just below and just above the 11-bit boundary, the most negative input, and a full-scale positive input.

// File: rtl/nrm_pkg.sv
package nrm_pkg;

  // Number of vector components handled side by side.
  localparam int NRM_COMP = 3;

  // Right shift needed so a value that occupies width_used bits fits in fit_w bits.
  function automatic int shift_needed(input int width_used, input int fit_w);
    return (width_used > fit_w) ? (width_used - fit_w) : 0;
  endfunction

endpackage

// File: rtl/nrm_mag_split.sv
// Stage 1: split each component into sign and ones-complement magnitude.
module nrm_mag_split #(
  parameter  int IN_W = 24,
  parameter  int NC   = 3,
  localparam int MW   = IN_W - 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   vld_i,
  input  logic [NC-1:0][IN_W-1:0] comp_i,
  output logic                   vld_o,
  output logic [NC-1:0][MW-1:0]  mag_o,
  output logic [NC-1:0]          sgn_o
);

  function automatic logic [MW-1:0] ones_mag(input logic [IN_W-1:0] v);
    return v[MW-1:0] ^ {MW{v[IN_W-1]}};
  endfunction

  logic [NC-1:0][MW-1:0] mag_d;
  logic [NC-1:0]         sgn_d;

  for (genvar c = 0; c < NC; c++) begin : g_comp
    assign mag_d[c] = ones_mag(comp_i[c]);
    assign sgn_d[c] = comp_i[c][IN_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      mag_o <= '0;
      sgn_o <= '0;
    end else begin
      vld_o <= vld_i;
      mag_o <= mag_d;
      sgn_o <= sgn_d;
    end
  end

endmodule

// File: rtl/nrm_shift_ctrl.sv
// Stage 2: derive the shared shift count from the leading one of all magnitudes.
module nrm_shift_ctrl #(
  parameter  int MW     = 23,
  parameter  int OMAG_W = 11,
  parameter  int NC     = 3,
  localparam int KMAX   = MW - OMAG_W,
  localparam int KW     = $clog2(KMAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  vld_i,
  input  logic [NC-1:0][MW-1:0] mag_i,
  input  logic [NC-1:0]         sgn_i,
  output logic                  vld_o,
  output logic [NC-1:0][MW-1:0] mag_o,
  output logic [NC-1:0]         sgn_o,
  output logic [KW-1:0]         k_o
);

  // Leading one of the OR equals leading one of the largest magnitude.
  function automatic logic [KW-1:0] calc_k(input logic [MW-1:0] v);
    int msb;
    msb = -1;
    for (int i = 0; i < MW; i++) begin
      if (v[i]) msb = i;
    end
    return KW'(nrm_pkg::shift_needed(msb + 1, OMAG_W));
  endfunction

  logic [MW-1:0] mag_or;
  logic [KW-1:0] k_d;

  always_comb begin
    mag_or = '0;
    for (int c = 0; c < NC; c++) mag_or = mag_or | mag_i[c];
    k_d = calc_k(mag_or);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      mag_o <= '0;
      sgn_o <= '0;
      k_o   <= '0;
    end else begin
      vld_o <= vld_i;
      mag_o <= mag_i;
      sgn_o <= sgn_i;
      k_o   <= k_d;
    end
  end

endmodule

// File: rtl/nrm_shift_cascade.sv
// Chain of fixed power-of-two right shifters; bit j of k_i enables the 2**j stage.
module nrm_shift_cascade #(
  parameter int MW = 23,
  parameter int KW = 4
) (
  input  logic [MW-1:0] mag_i,
  input  logic [KW-1:0] k_i,
  output logic [MW-1:0] mag_o
);

  logic [KW:0][MW-1:0] chain;

  assign chain[0] = mag_i;

  for (genvar j = 0; j < KW; j++) begin : g_stage
    assign chain[j+1] = k_i[j] ? (chain[j] >> (2 ** j)) : chain[j];
  end

  assign mag_o = chain[KW];

endmodule

// File: rtl/normal_prescaler.sv
module normal_prescaler #(
  parameter  int IN_W   = 24,
  parameter  int OUT_W  = 12,
  localparam int NC     = nrm_pkg::NRM_COMP,
  localparam int MW     = IN_W - 1,
  localparam int OMAG_W = OUT_W - 1,
  localparam int KMAX   = MW - OMAG_W,
  localparam int KW     = $clog2(KMAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [IN_W-1:0] in_x,
  input  logic [IN_W-1:0] in_y,
  input  logic [IN_W-1:0] in_z,
  output logic            out_vld,
  output logic [OUT_W-1:0] out_x,
  output logic [OUT_W-1:0] out_y,
  output logic [OUT_W-1:0] out_z
);

  logic [NC-1:0][IN_W-1:0] in_comp;
  assign in_comp = {in_z, in_y, in_x};

  // Stage 1 outputs
  logic                  s1_vld;
  logic [NC-1:0][MW-1:0] s1_mag;
  logic [NC-1:0]         s1_sgn;

  // Stage 2 outputs
  logic                  s2_vld;
  logic [NC-1:0][MW-1:0] s2_mag;
  logic [NC-1:0]         s2_sgn;
  logic [KW-1:0]         s2_k;

  // Shifter results and observation wires
  logic [NC-1:0][MW-1:0]     casc_full;
  logic [NC-1:0]             casc_over;
  logic [NC-1:0][OMAG_W-1:0] nxt_mag;
  logic [NC-1:0]             nxt_sgn;
  logic                      any_over;

  // Stage 3 registers
  logic                      out_vld_q;
  logic [NC-1:0][OMAG_W-1:0] out_mag_q;
  logic [NC-1:0]             out_sgn_q;
  logic [KW-1:0]             k_q;
  logic                      out_lead;

  nrm_mag_split #(.IN_W(IN_W), .NC(NC)) u_split (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (in_vld),
    .comp_i(in_comp),
    .vld_o (s1_vld),
    .mag_o (s1_mag),
    .sgn_o (s1_sgn)
  );

  nrm_shift_ctrl #(.MW(MW), .OMAG_W(OMAG_W), .NC(NC)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (s1_vld),
    .mag_i (s1_mag),
    .sgn_i (s1_sgn),
    .vld_o (s2_vld),
    .mag_o (s2_mag),
    .sgn_o (s2_sgn),
    .k_o   (s2_k)
  );

  for (genvar c = 0; c < NC; c++) begin : g_lane
    nrm_shift_cascade #(.MW(MW), .KW(KW)) u_casc (
      .mag_i(s2_mag[c]),
      .k_i  (s2_k),
      .mag_o(casc_full[c])
    );
    assign casc_over[c] = |casc_full[c][MW-1:OMAG_W];
    assign nxt_mag[c]   = casc_full[c][OMAG_W-1:0];
    assign nxt_sgn[c]   = s2_sgn[c] & (|casc_full[c][OMAG_W-1:0]);
  end

  assign any_over = |casc_over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld_q <= 1'b0;
      out_mag_q <= '0;
      out_sgn_q <= '0;
      k_q       <= '0;
    end else begin
      out_vld_q <= s2_vld;
      out_mag_q <= nxt_mag;
      out_sgn_q <= nxt_sgn;
      k_q       <= s2_k;
    end
  end

  always_comb begin
    out_lead = 1'b0;
    for (int c = 0; c < NC; c++) out_lead = out_lead | out_mag_q[c][OMAG_W-1];
  end

  assign out_vld = out_vld_q;
  assign out_x   = {out_sgn_q[0], out_mag_q[0]};
  assign out_y   = {out_sgn_q[1], out_mag_q[1]};
  assign out_z   = {out_sgn_q[2], out_mag_q[2]};

endmodule

// File: rtl/normal_prescaler_chk.sv
module normal_prescaler_chk #(
  parameter int NC     = 3,
  parameter int MW     = 23,
  parameter int OMAG_W = 11,
  parameter int KW     = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      s2_vld,
  input logic [NC-1:0][MW-1:0]     s2_mag,
  input logic [NC-1:0]             s2_sgn,
  input logic [KW-1:0]             s2_k,
  input logic                      any_over,
  input logic [KW-1:0]             k_q,
  input logic                      out_lead,
  input logic                      out_vld,
  input logic [NC-1:0][OMAG_W-1:0] out_mag,
  input logic [NC-1:0]             out_sgn
);

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == $past(s2_vld));  // R1

  AST_SHIFT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    s2_vld |-> !any_over);  // R3

  AST_LEAD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && k_q != '0) |-> out_lead);  // R7

  for (genvar c = 0; c < NC; c++) begin : g_lane_chk
    AST_NO_SHIFT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_vld && s2_k == '0) |=> out_mag[c] == $past(s2_mag[c][OMAG_W-1:0]));  // R4

    AST_POS_STAYS_POS: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_vld && !s2_sgn[c]) |=> !out_sgn[c]);  // R2

    AST_ZERO_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_mag[c] == '0) |-> !out_sgn[c]);  // R6
  end

endmodule

bind normal_prescaler normal_prescaler_chk #(
  .NC(NC), .MW(MW), .OMAG_W(OMAG_W), .KW(KW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .s2_vld  (s2_vld),
  .s2_mag  (s2_mag),
  .s2_sgn  (s2_sgn),
  .s2_k    (s2_k),
  .any_over(any_over),
  .k_q     (k_q),
  .out_lead(out_lead),
  .out_vld (out_vld),
  .out_mag (out_mag_q),
  .out_sgn (out_sgn_q)
);

// File: tb/sim_normal_prescaler.sv
`timescale 1ns/1ps
module sim_normal_prescaler;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [23:0] in_x = '0, in_y = '0, in_z = '0;
  logic        out_vld;
  logic [11:0] out_x, out_y, out_z;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  normal_prescaler u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .in_x(in_x), .in_y(in_y), .in_z(in_z),
    .out_vld(out_vld), .out_x(out_x), .out_y(out_y), .out_z(out_z)
  );

  // Scenario queue
  logic [23:0] qx[64], qy[64], qz[64];
  bit          qv[64];
  int          qn = 0;

  task automatic push(input logic [23:0] x, input logic [23:0] y, input logic [23:0] z);
    qx[qn] = x; qy[qn] = y; qz[qn] = z; qv[qn] = 1'b1; qn++;
  endtask

  task automatic gap();
    qx[qn] = '0; qy[qn] = '0; qz[qn] = '0; qv[qn] = 1'b0; qn++;
  endtask

  // Reference model built from the requirement text.
  function automatic logic [22:0] ref_mag(input logic [23:0] v);
    return v[23] ? ~v[22:0] : v[22:0];
  endfunction

  function automatic logic [35:0] ref_triple(input logic [23:0] x, input logic [23:0] y,
                                             input logic [23:0] z);
    logic [22:0] m[3];
    logic [23:0] v[3];
    logic [22:0] biggest, sh;
    logic [35:0] r;
    int k;
    v[0] = x; v[1] = y; v[2] = z;
    biggest = '0;
    for (int c = 0; c < 3; c++) begin
      m[c] = ref_mag(v[c]);
      if (m[c] > biggest) biggest = m[c];
    end
    k = 0;
    while ((biggest >> k) > 23'd2047) k++;
    r = '0;
    for (int c = 0; c < 3; c++) begin
      sh = m[c] >> k;
      r[c*12 +: 12] = {(sh != 0) && v[c][23], sh[10:0]};
    end
    return r;
  endfunction

  task automatic check_slot(input int j, input string tag);
    logic [35:0] e;
    n_chk++;
    if (!qv[j]) begin
      if (out_vld !== 1'b0) begin
        n_bad++;
        $display("FAIL %s slot %0d: out_vld=%b expected 0", tag, j, out_vld);
      end
    end else begin
      e = ref_triple(qx[j], qy[j], qz[j]);
      if (out_vld !== 1'b1 || {out_z, out_y, out_x} !== e) begin
        n_bad++;
        $display("FAIL %s slot %0d: vld=%b x=%h y=%h z=%h expected vld=1 x=%h y=%h z=%h",
                 tag, j, out_vld, out_x, out_y, out_z, e[11:0], e[23:12], e[35:24]);
      end
    end
  endtask

  // Drive queued slots on falling edges; output of slot i is due three falling edges later.
  task automatic run_queue(input string tag);
    for (int i = 0; i < qn + 3; i++) begin
      @(negedge clk);
      if (i >= 3) check_slot(i - 3, tag);
      if (i < qn) begin
        in_vld = qv[i]; in_x = qx[i]; in_y = qy[i]; in_z = qz[i];
      end else begin
        in_vld = 1'b0;
      end
    end
    qn = 0;
  endtask

  task automatic t_reset();  // R8
    @(negedge clk);
    n_chk++;
    if (out_vld !== 1'b0 || out_x !== '0 || out_y !== '0 || out_z !== '0) begin
      n_bad++;
      $display("FAIL R8 reset: vld=%b x=%h y=%h z=%h expected all 0", out_vld, out_x, out_y, out_z);
    end
  endtask

  task automatic t_small();  // R4, R5
    push(24'd5, 24'd2047, 24'd100);
    push(24'd0, 24'd1, 24'd2);
    push(24'd1024, 24'd0, 24'd2047);
    run_queue("R4/R5");
  endtask

  task automatic t_negative();  // R2
    push(-24'sd5, 24'd7, -24'sd100);
    push(-24'sd2048, 24'd3, 24'd0);
    push(-24'sd2049, -24'sd2, 24'd9);
    run_queue("R2");
  endtask

  task automatic t_shift();  // R3, R7
    push(24'd2048, 24'd1, -24'sd3000);
    push(24'h400000, 24'h001234, -24'sd16);
    push(24'd4095, 24'd4095, 24'd4095);
    push(24'd0, 24'h00FFFF, -24'sd40000);
    run_queue("R3/R7");
  endtask

  task automatic t_fullscale();  // R9
    push(24'h7FFFFF, 24'h800000, 24'd0);
    push(24'h800000, 24'h800000, 24'h800000);
    run_queue("R9");
  endtask

  task automatic t_zero();  // R6
    push(-24'sd1, -24'sd1, 24'd5);
    push(24'd1, -24'sd2, 24'h100000);
    push(24'd0, 24'd0, 24'd0);
    run_queue("R6");
  endtask

  task automatic t_bubbles();  // R1
    push(24'd300, 24'd4000, -24'sd7);
    gap();
    push(-24'sd70000, 24'd11, 24'd12);
    gap();
    gap();
    push(24'd9, 24'd8, 24'd7);
    push(24'h3FFFFF, -24'sd1, 24'd2);
    run_queue("R1");
  endtask

  task automatic t_stream();  // R1, R3
    logic [31:0] s;
    logic [23:0] v[3];
    s = 32'h1ACE_B00C;
    for (int i = 0; i < 40; i++) begin
      for (int c = 0; c < 3; c++) begin
        s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
        v[c] = 24'($signed(s[23:0]) >>> ((i + c * 7) % 22));
      end
      push(v[0], v[1], v[2]);
    end
    run_queue("R1/R3");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_small();
    t_negative();
    t_shift();
    t_fullscale();
    t_zero();
    t_bubbles();
    t_stream();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule